// File: doc/BRIEF.md
# Shared-Counter Dual-Channel PWM Timer

This peripheral produces edge-aligned pulse-width-modulated outputs from a single up-counter that all channels share. A power-of-two prescaler sets the counter's rate, and a period register sets the value at which the counter wraps back to zero. Each channel compares the counter against its own threshold. A per-channel control field enables the channel and picks the polarity: high-true or low-true.

Software reaches every register through a simple synchronous bus. A write is taken on the clock edge where `bus_sel` and `bus_we` are both high. Read data is combinational from `bus_addr`. New period and threshold values go into holding registers and move into the working copies only when the counter wraps, so a period that is already running never sees a partial update. While the counter is stopped, the working copies follow the holding registers. A sticky per-channel flag records that the counter reached the channel's threshold.

Top module: `dual_pwm_timer`

## Requirements
- R1: After reset every register reads zero, except the period register, which reads 0xFFFF, and every output is low. Register offsets: control 0x10, counter 0x14, period 0x18, channel n control 0x20+8n, channel n threshold 0x24+8n.
- R2: The control register holds the prescale exponent in bits [2:0]. The counter advances once every 2^exponent clocks, so one full period lasts (period+1)·2^exponent clocks.
- R3: The counter counts from 0 up to the working period value and returns to 0 on the next advance. It never reads above that value.
- R4: The counter runs only when control bits [4:3] equal 01. Any other code stops it, and the count holds its value.
- R5: In high-true mode (channel control bit 5 = 1 and bit 3 = 1), the output is high while count < threshold. A threshold of 0 gives a constant low output. A threshold above the period gives a constant high output.
- R6: In low-true mode (bit 5 = 1, bit 3 = 0, bit 2 = 1), the output is the complement of the high-true waveform. When bits 3 and 2 are both set, the channel behaves as high-true.
- R7: A channel with bit 5 clear, or with bits 3 and 2 both clear, drives its output low. The other channel and the counter are not affected.
- R8: While the counter is stopped, a high-true channel drives low and a low-true channel drives high.
- R9: Writes to the period and threshold registers read back at once. While the counter runs, they take effect only at the next wrap. While it is stopped, they take effect within two clocks.
- R10: Any write to the counter register resets the count and the prescaler to zero.
- R11: Channel control bit 7 is set when the counter advances to the channel's working threshold. Writing 1 to bit 7 clears it and writing 0 leaves it unchanged. A new match takes priority over a clear in the same clock. No match can occur while the counter is stopped.
- R12: Control bit 5 (center-aligned counting) always reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| pwm_out | output | NCH (2) | One PWM output per channel |

## Verification
The checker checks on every cycle that the counter returns to zero after it reaches the working period, and that it holds while stopped. It also checks that writes to the counter clear it, and that the working period and thresholds stay frozen between wraps while the counter runs. Disabled channels and stopped channels must show the correct idle level, and a flag must stay set until a clear is written. Some behaviours can only be seen over a run of cycles: the exact period length for each prescale setting, the number of high cycles for each threshold, when a buffered write first becomes visible, and when a flag gets set. The bench measures these by sweeping prescale, period and threshold values and comparing the results with values computed from arithmetic.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
   // register offsets; channel pairs repeat at a fixed stride
   localparam int OFS_CTRL      = 'h10;
   localparam int OFS_COUNT     = 'h14;
   localparam int OFS_PERIOD    = 'h18;
   localparam int OFS_CH_BASE   = 'h20;
   localparam int OFS_CH_STRIDE = 'h08;
   localparam int OFS_THR_DELTA = 'h04;

   // channel control bit positions
   localparam int BIT_FLAG = 7;
   localparam int BIT_MSB  = 5;
   localparam int BIT_MSA  = 4;
   localparam int BIT_ELSB = 3;
   localparam int BIT_ELSA = 2;

   // control register field positions
   localparam int          CMOD_LSB = 3;
   localparam logic [1:0]  CMOD_RUN = 2'b01;

   typedef struct packed {
      logic msb;
      logic msa;
      logic elsb;
      logic elsa;
   } ch_cfg_t;

   typedef enum logic [1:0] {
      MODE_OFF  = 2'd0,
      MODE_HIGH = 2'd1,
      MODE_LOW  = 2'd2
   } ch_mode_e;

   function automatic ch_mode_e decode_mode(input ch_cfg_t c);
      if (!c.msb)     return MODE_OFF;
      else if (c.elsb) return MODE_HIGH;
      else if (c.elsa) return MODE_LOW;
      else             return MODE_OFF;
   endfunction
endpackage

// File: rtl/dpt_prescaler.sv
module dpt_prescaler #(
   parameter int PS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            restart,
   input  logic [PS_W-1:0] ps,
   output logic            tick
);
   localparam int DIV_W = (1 << PS_W) - 1;
   localparam int LIM_W = DIV_W + 1;

   logic [DIV_W-1:0] div_q;
   logic [LIM_W-1:0] lim;

   assign lim  = (LIM_W'(1) << ps) - LIM_W'(1);
   assign tick = run && ({1'b0, div_q} >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      div_q <= '0;
      else if (restart || !run || tick) div_q <= '0;
      else                             div_q <= div_q + DIV_W'(1);
   end
endmodule

// File: rtl/dpt_counter.sv
module dpt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             restart,
   input  logic             per_wr,
   input  logic [CNT_W-1:0] per_wdata,
   output logic [CNT_W-1:0] per_buf,
   output logic [CNT_W-1:0] per_act,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             wrap,
   output logic             reload
);
   assign wrap    = tick && (cnt >= per_act);
   assign cnt_nxt = wrap ? '0 : cnt + CNT_W'(1);
   assign reload  = wrap || !run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (tick)    cnt <= cnt_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      per_buf <= '1;
      else if (per_wr) per_buf <= per_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      per_act <= '1;
      else if (reload) per_act <= per_buf;
   end
endmodule

// File: rtl/dpt_channel.sv
module dpt_channel
   import dpt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             reload,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic             cfg_wr,
   input  ch_cfg_t          cfg_wdata,
   input  logic             flag_clr,
   input  logic             thr_wr,
   input  logic [CNT_W-1:0] thr_wdata,
   output ch_cfg_t          cfg,
   output logic             flag,
   output logic [CNT_W-1:0] thr_buf,
   output logic [CNT_W-1:0] thr_act,
   output logic             pwm
);
   ch_mode_e mode;
   logic     below;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg <= '0;
      else if (cfg_wr) cfg <= cfg_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       flag <= 1'b0;
      else if (tick && cnt_nxt == thr_act) flag <= 1'b1;
      else if (flag_clr)                flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      thr_buf <= '0;
      else if (thr_wr) thr_buf <= thr_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      thr_act <= '0;
      else if (reload) thr_act <= thr_buf;
   end

   always_comb begin
      mode  = decode_mode(cfg);
      below = cnt < thr_act;
      case (mode)
         MODE_HIGH: pwm = run && below;
         MODE_LOW:  pwm = !run || !below;
         default:   pwm = 1'b0;
      endcase
   end
endmodule

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer
   import dpt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NCH    = 2,
   parameter int PS_W   = 3,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NCH-1:0]    pwm_out
);
   localparam int MAP_END = OFS_CH_BASE + NCH * OFS_CH_STRIDE;

   if (CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must not exceed DATA_W");
   end
   if (DATA_W < 8) begin : g_bad_data_w
      $error("DATA_W must hold the channel control byte");
   end
   if (PS_W < 1 || PS_W > CMOD_LSB) begin : g_bad_ps_w
      $error("PS_W must lie in 1..3 to stay below the clock-mode field");
   end
   if (NCH < 1 || MAP_END > (1 << ADDR_W)) begin : g_bad_map
      $error("channel registers do not fit in the address space");
   end

   logic              wr_en;
   logic [PS_W-1:0]   ps_q;
   logic [1:0]        cmod_q;
   logic              run;
   logic              cnt_wr;
   logic              tick;
   logic              wrap;
   logic              reload;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_nxt;
   logic [CNT_W-1:0]  per_buf;
   logic [CNT_W-1:0]  per_act;
   ch_cfg_t [NCH-1:0] cfg_q;
   logic [NCH-1:0]    flag_q;
   logic [NCH-1:0][CNT_W-1:0] thr_buf;
   logic [NCH-1:0][CNT_W-1:0] thr_act;
   logic              unused_wdata;

   assign wr_en        = bus_sel && bus_we;
   assign run          = (cmod_q == CMOD_RUN);
   assign cnt_wr       = wr_en && (bus_addr == ADDR_W'(OFS_COUNT));
   assign unused_wdata = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_q   <= '0;
         cmod_q <= '0;
      end else if (wr_en && bus_addr == ADDR_W'(OFS_CTRL)) begin
         ps_q   <= bus_wdata[PS_W-1:0];
         cmod_q <= bus_wdata[CMOD_LSB +: 2];
      end
   end

   dpt_prescaler #(.PS_W(PS_W)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (cnt_wr),
      .ps      (ps_q),
      .tick    (tick)
   );

   dpt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .tick      (tick),
      .restart   (cnt_wr),
      .per_wr    (wr_en && bus_addr == ADDR_W'(OFS_PERIOD)),
      .per_wdata (bus_wdata[CNT_W-1:0]),
      .per_buf   (per_buf),
      .per_act   (per_act),
      .cnt       (cnt_q),
      .cnt_nxt   (cnt_nxt),
      .wrap      (wrap),
      .reload    (reload)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CH_BASE + g * OFS_CH_STRIDE);
      localparam logic [ADDR_W-1:0] A_THR = ADDR_W'(OFS_CH_BASE + g * OFS_CH_STRIDE + OFS_THR_DELTA);
      logic    cfg_hit;
      ch_cfg_t cfg_in;

      assign cfg_hit = wr_en && (bus_addr == A_CFG);
      assign cfg_in  = '{msb:  bus_wdata[BIT_MSB],
                         msa:  bus_wdata[BIT_MSA],
                         elsb: bus_wdata[BIT_ELSB],
                         elsa: bus_wdata[BIT_ELSA]};

      dpt_channel #(.CNT_W(CNT_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .run       (run),
         .tick      (tick),
         .reload    (reload),
         .cnt       (cnt_q),
         .cnt_nxt   (cnt_nxt),
         .cfg_wr    (cfg_hit),
         .cfg_wdata (cfg_in),
         .flag_clr  (cfg_hit && bus_wdata[BIT_FLAG]),
         .thr_wr    (wr_en && bus_addr == A_THR),
         .thr_wdata (bus_wdata[CNT_W-1:0]),
         .cfg       (cfg_q[g]),
         .flag      (flag_q[g]),
         .thr_buf   (thr_buf[g]),
         .thr_act   (thr_act[g]),
         .pwm       (pwm_out[g])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_CTRL)) begin
         bus_rdata[PS_W-1:0]     = ps_q;
         bus_rdata[CMOD_LSB +: 2] = cmod_q;
      end else if (bus_addr == ADDR_W'(OFS_COUNT)) begin
         bus_rdata[CNT_W-1:0] = cnt_q;
      end else if (bus_addr == ADDR_W'(OFS_PERIOD)) begin
         bus_rdata[CNT_W-1:0] = per_buf;
      end
      for (int i = 0; i < NCH; i++) begin
         if (bus_addr == ADDR_W'(OFS_CH_BASE + i * OFS_CH_STRIDE)) begin
            bus_rdata[BIT_FLAG] = flag_q[i];
            bus_rdata[BIT_MSB]  = cfg_q[i].msb;
            bus_rdata[BIT_MSA]  = cfg_q[i].msa;
            bus_rdata[BIT_ELSB] = cfg_q[i].elsb;
            bus_rdata[BIT_ELSA] = cfg_q[i].elsa;
         end
         if (bus_addr == ADDR_W'(OFS_CH_BASE + i * OFS_CH_STRIDE + OFS_THR_DELTA)) begin
            bus_rdata[CNT_W-1:0] = thr_buf[i];
         end
      end
   end
endmodule

// File: rtl/dual_pwm_timer_chk.sv
module dual_pwm_timer_chk
   import dpt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NCH    = 2,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              run,
   input logic              tick,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  per_act,
   input logic [NCH-1:0][CNT_W-1:0] thr_act,
   input ch_cfg_t [NCH-1:0] cfg,
   input logic [NCH-1:0]    flag,
   input logic [NCH-1:0]    pwm_out
);
   logic wr_en, cnt_wr, at_wrap;
   assign wr_en   = bus_sel && bus_we;
   assign cnt_wr  = wr_en && (bus_addr == ADDR_W'(OFS_COUNT));
   assign at_wrap = tick && (cnt >= per_act);

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      at_wrap |=> cnt == '0); // R3
   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(cnt)); // R4
   AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> cnt == '0); // R10
   AST_PERIOD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !at_wrap) |=> $stable(per_act)); // R9

   for (genvar g = 0; g < NCH; g++) begin : g_chk
      logic clr_wr;
      assign clr_wr = wr_en && bus_wdata[BIT_FLAG] &&
                      (bus_addr == ADDR_W'(OFS_CH_BASE + g * OFS_CH_STRIDE));

      AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         (decode_mode(cfg[g]) == MODE_OFF) |-> !pwm_out[g]); // R7
      AST_STOP_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         (!run && decode_mode(cfg[g]) == MODE_HIGH) |-> !pwm_out[g]); // R8
      AST_STOP_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         (!run && decode_mode(cfg[g]) == MODE_LOW) |-> pwm_out[g]); // R8
      AST_THR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
         (run && !at_wrap) |=> $stable(thr_act[g])); // R9
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flag[g] && !clr_wr) |=> flag[g]); // R11
      AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (!run && !flag[g]) |=> !flag[g]); // R11
   end
endmodule

bind dual_pwm_timer dual_pwm_timer_chk #(
   .CNT_W  (CNT_W),
   .NCH    (NCH),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .run       (run),
   .tick      (tick),
   .cnt       (cnt_q),
   .per_act   (per_act),
   .thr_act   (thr_act),
   .cfg       (cfg_q),
   .flag      (flag_q),
   .pwm_out   (pwm_out)
);

// File: tb/dual_pwm_timer_bench.sv
module dual_pwm_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic [1:0]  pwm_out;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   localparam logic [31:0] CFG_HIGH = 32'h28;
   localparam logic [31:0] CFG_LOW  = 32'h24;

   dual_pwm_timer u_dual_pwm_timer (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwm_out(pwm_out)
   );

   always #5 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic sample(output int c, output logic [1:0] p);
      @(negedge clk);
      bus_addr = 8'h14;
      #1;
      c = int'(bus_rdata[15:0]);
      p = pwm_out;
   endtask

   task automatic configure(input int ps, input int per, input int v0, input int v1,
                            input logic [31:0] c0, input logic [31:0] c1);
      wr(8'h10, 32'(ps));
      wr(8'h18, 32'(per));
      wr(8'h24, 32'(v0));
      wr(8'h2C, 32'(v1));
      wr(8'h20, c0);
      wr(8'h28, c1);
      wr(8'h14, 32'h0);
      repeat (2) @(negedge clk);
   endtask

   task automatic start(input int ps);
      wr(8'h10, 32'h8 | 32'(ps));
   endtask

   task automatic period_max(output int mx);
      int c;
      logic [1:0] p;
      bit seen;
      seen = 1'b0;
      mx = 0;
      for (int k = 0; k < 2000; k++) begin
         sample(c, p);
         if (c == 0 && seen) break;
         if (c != 0) seen = 1'b1;
         if (c > mx) mx = c;
      end
   endtask

   task automatic wait_count(input int target);
      int c;
      logic [1:0] p;
      for (int k = 0; k < 2000; k++) begin
         sample(c, p);
         if (c == target) break;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired actual %0d expected %0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, d2;
      int c, mx;
      logic [1:0] p;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      rd(8'h10, d); check("R1 ctrl", d, 32'h0);
      rd(8'h14, d); check("R1 count", d, 32'h0);
      rd(8'h18, d); check("R1 period", d, 32'hFFFF);
      rd(8'h20, d); check("R1 ch0 ctrl", d, 32'h0);
      rd(8'h28, d); check("R1 ch1 ctrl", d, 32'h0);
      rd(8'h24, d); check("R1 ch0 thr", d, 32'h0);
      rd(8'h2C, d); check("R1 ch1 thr", d, 32'h0);
      check("R1 outputs", 32'(pwm_out), 32'h0);

      // R2 / R3 period length and top value across prescale and period
      for (int ps = 0; ps < 4; ps++) begin
         for (int mi = 0; mi < 2; mi++) begin
            int per, plen, first, second, prevc;
            per = (mi == 0) ? 2 : 5;
            plen = (per + 1) << ps;
            configure(ps, per, 1, 1, CFG_HIGH, CFG_LOW);
            start(ps);
            first = -1; second = -1; prevc = -1; mx = 0;
            for (int k = 0; k < 3 * plen + 8; k++) begin
               sample(c, p);
               if (c == 0 && prevc > 0) begin
                  if (first < 0) first = k;
                  else if (second < 0) second = k;
               end
               if (c > mx) mx = c;
               prevc = c;
            end
            check("R2 period length", 32'(second - first), 32'(plen));
            check("R3 top count", 32'(mx), 32'(per));
         end
      end

      // R5 / R6 duty sweep, threshold 0 .. period+2
      for (int v = 0; v < 7; v++) begin
         int hi0, hi1, mis, expv;
         configure(1, 4, v, v, CFG_HIGH, CFG_LOW);
         start(1);
         repeat (3) sample(c, p);
         hi0 = 0; hi1 = 0; mis = 0;
         for (int k = 0; k < 10; k++) begin
            sample(c, p);
            hi0 += int'(p[0]);
            hi1 += int'(p[1]);
            if (p[0] !== (c < v)) mis++;
         end
         expv = (v > 4) ? 10 : v * 2;
         check("R5 high-true duty", 32'(hi0), 32'(expv));
         check("R6 low-true duty", 32'(hi1), 32'(10 - expv));
         check("R5 level vs count", 32'(mis), 32'h0);
      end

      // R6 both level bits set acts high-true
      begin
         int hi0;
         configure(1, 4, 2, 2, 32'h2C, 32'h2C);
         start(1);
         repeat (3) sample(c, p);
         hi0 = 0;
         for (int k = 0; k < 10; k++) begin
            sample(c, p);
            hi0 += int'(p[0]);
         end
         check("R6 both level bits", 32'(hi0), 32'd4);
      end

      // R9 buffered threshold
      begin
         int bad;
         configure(0, 7, 2, 0, CFG_HIGH, 32'h0);
         start(0);
         wait_count(3);
         wr(8'h24, 32'd6);
         rd(8'h24, d); check("R9 threshold readback", d, 32'd6);
         bad = 0;
         for (int k = 0; k < 50; k++) begin
            sample(c, p);
            if (c == 0) break;
            if (p[0]) bad++;
         end
         check("R9 old threshold kept", 32'(bad), 32'h0);
         wait_count(4);
         check("R9 new threshold after wrap", 32'(pwm_out[0]), 32'h1);
      end

      // R9 buffered period
      wait_count(2);
      wr(8'h18, 32'd3);
      rd(8'h18, d); check("R9 period readback", d, 32'd3);
      period_max(mx); check("R9 old period kept", 32'(mx), 32'd7);
      period_max(mx); check("R9 new period after wrap", 32'(mx), 32'd3);

      // R11 compare flag
      wr(8'h20, 32'h80 | CFG_HIGH);
      repeat (10) @(negedge clk);
      rd(8'h20, d); check("R11 no match no flag", d, CFG_HIGH);
      wr(8'h24, 32'd2);
      repeat (12) @(negedge clk);
      rd(8'h20, d); check("R11 flag on match", d, 32'h80 | CFG_HIGH);
      wr(8'h10, 32'h0);
      wr(8'h20, CFG_HIGH);
      rd(8'h20, d); check("R11 write 0 keeps flag", d, 32'h80 | CFG_HIGH);
      wr(8'h20, 32'h80 | CFG_HIGH);
      rd(8'h20, d); check("R11 write 1 clears flag", d, CFG_HIGH);
      repeat (6) @(negedge clk);
      rd(8'h20, d); check("R11 no set while stopped", d, CFG_HIGH);

      // R4 / R8 stopped behaviour
      rd(8'h14, d);
      repeat (5) @(negedge clk);
      rd(8'h14, d2); check("R4 count holds when stopped", d2, d);
      wr(8'h28, CFG_LOW);
      check("R8 idle levels", 32'(pwm_out), 32'h2);
      wr(8'h10, 32'h10);
      rd(8'h10, d); check("R4 reserved code readback", d, 32'h10);
      rd(8'h14, d);
      repeat (5) @(negedge clk);
      rd(8'h14, d2); check("R4 reserved code stops", d2, d);
      check("R8 idle levels reserved code", 32'(pwm_out), 32'h2);

      // R7 disabled channel
      begin
         int hi0, hi1;
         configure(0, 3, 2, 2, CFG_HIGH, 32'h0);
         start(0);
         hi0 = 0; hi1 = 0;
         for (int k = 0; k < 8; k++) begin
            sample(c, p);
            hi0 += int'(p[0]);
            hi1 += int'(p[1]);
         end
         check("R7 disabled channel low", 32'(hi1), 32'h0);
         check("R7 other channel unaffected", 32'(hi0), 32'd4);
         period_max(mx); check("R7 counter keeps running", 32'(mx), 32'd3);
         wr(8'h28, 32'h08);
         hi1 = 0;
         for (int k = 0; k < 8; k++) begin
            sample(c, p);
            hi1 += int'(p[1]);
         end
         check("R7 mode bit clear disables", 32'(hi1), 32'h0);
      end

      // R10 counter write
      repeat (3) sample(c, p);
      wr(8'h14, 32'h1234);
      rd(8'h14, d); check("R10 count write clears", d, 32'h0);

      // R12 center-aligned bit ignored
      wr(8'h10, 32'h2A);
      rd(8'h10, d); check("R12 center bit reads 0", d, 32'h0A);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule